// File: doc/BRIEF.md
# SAR ADC conversion controller

This block is the digital sequencer for a 10-bit successive-approximation analog-to-digital converter. It runs entirely on the system oscillator clock. A conversion-clock enable comes from two cascaded counters: a machine-clock divider selectable as divide-by-4, 64 or 1024, followed by a 4-bit prescaler that divides by N+1. Each conversion lasts exactly 16 conversion-clock periods.

A one-cycle start request launches a conversion. The controller first holds a sample strobe to the sample-hold stage for five conversion-clock periods. It then resolves one result bit per period, most significant first. In each step it presents a trial code to the DAC and reads back a single comparator bit. In the last period it stores the finished code and raises end-of-conversion. End-of-conversion stays high until the next start request is accepted. The analog parts (sample-hold, DAC, comparator) are outside this block.

Top module: `sar_adc_ctrl`

## Requirements
- R1: The conversion-clock period P, in oscillator cycles, is M*(N+1). N is the prescale input (0..15) and M comes from the divider code: 2'b00 gives 4, 2'b01 gives 64, 2'b10 gives 1024, and 2'b11 also gives 1024.
- R2: End-of-conversion rises exactly 16*P oscillator cycles after the clock edge that accepts a start request.
- R3: The sample strobe goes high in the cycle after acceptance and stays high for exactly 5*P oscillator cycles. It is never high while end-of-conversion is high.
- R4: The trial code is 0 after acceptance. It becomes 10'h200 at the end of the fifth conversion-clock period. At each of the next ten period boundaries, the bit under test is kept when the comparator input is 1 (analog input at or above the DAC level) and cleared when it is 0, and the next lower bit is set to 1. With an ideal comparator, the result therefore equals the input code.
- R5: The result output is loaded only when end-of-conversion rises. It holds its value through the next conversion until that conversion completes.
- R6: A start request that arrives while a conversion is running is ignored, and the running conversion keeps its timing and its result.
- R7: End-of-conversion stays high from completion until a start request is accepted. It is low in the cycle after acceptance.
- R8: The divider code and prescale value are captured when a start request is accepted. Changing them during a conversion does not alter that conversion's timing.
- R9: Reset clears the trial code, the result, end-of-conversion and the sample strobe, and returns the sequencer to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_sel_i | input | 2 | Machine-clock divider code |
| presc_i | input | 4 | Prescale value N, divides by N+1 |
| start_i | input | 1 | Conversion start request, one cycle |
| cmp_i | input | 1 | Comparator: 1 when input is at or above DAC level |
| dac_code_o | output | 10 | Trial code driven to the DAC |
| sample_o | output | 1 | Sample strobe to the sample-hold stage |
| result_o | output | 10 | Last completed conversion result |
| eoc_o | output | 1 | End of conversion |

## Verification
Every result is due a fixed number of cycles after the accepting edge, with P recomputed in the bench from the divider code and prescale value. The trial code must be zero one cycle after that edge and 10'h200 exactly 5*P cycles later. The sample strobe must be high for 5*P sampled cycles, and end-of-conversion and the result must arrive 16*P cycles after acceptance. The driver records the accepting cycle and queues the expected result, latency and strobe width. The monitor samples one time unit after each rising edge and checks the measured values against the queued ones when end-of-conversion rises. A stray start request or a settings change made during a conversion would therefore show up as a latency mismatch.

// File: rtl/sar_pkg.sv
`timescale 1ns/1ps
package sar_pkg;
  localparam int MCNT_W = 11;

  // machine-clock ratio for a divider code; the unused code maps to the slowest rate
  function automatic logic [MCNT_W-1:0] mclk_ratio(input logic [1:0] code);
    case (code)
      2'b00:   mclk_ratio = MCNT_W'(4);
      2'b01:   mclk_ratio = MCNT_W'(64);
      default: mclk_ratio = MCNT_W'(1024);
    endcase
  endfunction

  // index of the bit resolved at a given step, negative outside the resolve window
  function automatic int resolve_bit(input int step, input int samp, input int res);
    if (step >= samp && step < samp + res) resolve_bit = samp + res - 1 - step;
    else resolve_bit = -1;
  endfunction
endpackage

// File: rtl/sar_clkgen.sv
`timescale 1ns/1ps
module sar_clkgen
  import sar_pkg::*;
#(
  parameter int PRE_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic [1:0]       div_i,
  input  logic [PRE_W-1:0] presc_i,
  output logic             ctick_o
);
  logic [MCNT_W-1:0] mcnt;
  logic [MCNT_W-1:0] mlim;
  logic [PRE_W-1:0]  pcnt;
  logic              mtick;

  assign mlim    = mclk_ratio(div_i) - MCNT_W'(1);
  assign mtick   = run_i && (mcnt == mlim);
  assign ctick_o = mtick && (pcnt == presc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mcnt <= '0;
      pcnt <= '0;
    end else if (clr_i || !run_i) begin
      mcnt <= '0;
      pcnt <= '0;
    end else begin
      if (mtick) mcnt <= '0;
      else       mcnt <= mcnt + MCNT_W'(1);
      if (ctick_o)    pcnt <= '0;
      else if (mtick) pcnt <= pcnt + PRE_W'(1);
    end
  end

  // R1
  pcnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (pcnt <= presc_i));
  // R1
  mcnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (mcnt <= mlim));
endmodule

// File: rtl/sar_seq.sv
`timescale 1ns/1ps
module sar_seq #(
  parameter int PRE_W    = 4,
  parameter int SAMP_CYC = 5,
  parameter int TOTAL    = 16,
  parameter int STEP_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              ctick_i,
  input  logic [1:0]        div_sel_i,
  input  logic [PRE_W-1:0]  presc_i,
  output logic              busy_o,
  output logic              accept_o,
  output logic [STEP_W-1:0] step_o,
  output logic              sample_o,
  output logic              eoc_o,
  output logic [1:0]        div_q_o,
  output logic [PRE_W-1:0]  presc_q_o
);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(TOTAL - 1);
  localparam logic [STEP_W-1:0] SAMP_END  = STEP_W'(SAMP_CYC);

  logic finish;

  assign accept_o = start_i && !busy_o;
  assign finish   = busy_o && ctick_i && (step_o == LAST_STEP);
  assign sample_o = busy_o && (step_o < SAMP_END);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o    <= 1'b0;
      step_o    <= '0;
      eoc_o     <= 1'b0;
      div_q_o   <= 2'b00;
      presc_q_o <= '0;
    end else if (accept_o) begin
      busy_o    <= 1'b1;
      step_o    <= '0;
      eoc_o     <= 1'b0;
      div_q_o   <= div_sel_i;
      presc_q_o <= presc_i;
    end else if (finish) begin
      busy_o <= 1'b0;
      step_o <= '0;
      eoc_o  <= 1'b1;
    end else if (busy_o && ctick_i) begin
      step_o <= step_o + STEP_W'(1);
    end
  end

  // R2
  eoc_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(eoc_o) |-> $past(ctick_i));
  // R3
  sample_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |-> !eoc_o);
  // R6 R8
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !ctick_i) |=> (busy_o && $stable(div_q_o) && $stable(presc_q_o)));
  // R7
  eoc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoc_o && !start_i) |=> eoc_o);
endmodule

// File: rtl/sar_reg.sv
`timescale 1ns/1ps
module sar_reg
  import sar_pkg::*;
#(
  parameter int RES      = 10,
  parameter int SAMP_CYC = 5,
  parameter int TOTAL    = 16,
  parameter int STEP_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              ctick_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic              cmp_i,
  output logic [RES-1:0]    trial_o,
  output logic [RES-1:0]    result_o
);
  localparam logic [RES-1:0]    MSB_ONE   = RES'(1) << (RES - 1);
  localparam logic [STEP_W-1:0] ARM_STEP  = STEP_W'(SAMP_CYC - 1);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(TOTAL - 1);

  logic [RES-1:0] trial_nxt;
  logic           arm;
  logic           store;

  assign arm   = ctick_i && (step_i == ARM_STEP);
  assign store = ctick_i && (step_i == LAST_STEP);

  always_comb begin
    int bidx;
    bidx      = resolve_bit(int'(step_i), SAMP_CYC, RES);
    trial_nxt = trial_o;
    if (step_i == ARM_STEP) begin
      trial_nxt = MSB_ONE;
    end else if (bidx >= 0) begin
      for (int i = 0; i < RES; i++) begin
        if (i == bidx)          trial_nxt[i] = cmp_i;
        else if (i + 1 == bidx) trial_nxt[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trial_o  <= '0;
      result_o <= '0;
    end else if (clr_i) begin
      trial_o <= '0;
    end else if (ctick_i) begin
      trial_o <= trial_nxt;
      if (store) result_o <= trial_o;
    end
  end

  // R4
  msb_arm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm && !clr_i) |=> (trial_o == MSB_ONE));
  // R5
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !store |=> $stable(result_o));
  // R4
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (trial_o == '0));
endmodule

// File: rtl/sar_adc_ctrl.sv
`timescale 1ns/1ps
module sar_adc_ctrl #(
  parameter int RES      = 10,
  parameter int PRE_W    = 4,
  parameter int SAMP_CYC = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       div_sel_i,
  input  logic [PRE_W-1:0] presc_i,
  input  logic             start_i,
  input  logic             cmp_i,
  output logic [RES-1:0]   dac_code_o,
  output logic             sample_o,
  output logic [RES-1:0]   result_o,
  output logic             eoc_o
);
  localparam int TOTAL  = SAMP_CYC + RES + 1;
  localparam int STEP_W = $clog2(TOTAL);

  logic              busy;
  logic              accept;
  logic              ctick;
  logic [STEP_W-1:0] step;
  logic [1:0]        div_q;
  logic [PRE_W-1:0]  presc_q;

  sar_seq #(
    .PRE_W(PRE_W), .SAMP_CYC(SAMP_CYC), .TOTAL(TOTAL), .STEP_W(STEP_W)
  ) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .ctick_i(ctick),
    .div_sel_i(div_sel_i), .presc_i(presc_i), .busy_o(busy), .accept_o(accept),
    .step_o(step), .sample_o(sample_o), .eoc_o(eoc_o),
    .div_q_o(div_q), .presc_q_o(presc_q)
  );

  sar_clkgen #(.PRE_W(PRE_W)) u_clk (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(busy), .clr_i(accept),
    .div_i(div_q), .presc_i(presc_q), .ctick_o(ctick)
  );

  sar_reg #(
    .RES(RES), .SAMP_CYC(SAMP_CYC), .TOTAL(TOTAL), .STEP_W(STEP_W)
  ) u_reg (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(accept), .ctick_i(ctick),
    .step_i(step), .cmp_i(cmp_i), .trial_o(dac_code_o), .result_o(result_o)
  );
endmodule

// File: tb/sim_sar_adc_ctrl.sv
`timescale 1ns/1ps
module sim_sar_adc_ctrl;
  typedef struct {
    logic [9:0] res;
    int         lat;
    int         samp;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] div = 2'b00;
  logic [3:0] presc = 4'd0;
  logic       start = 1'b0;
  logic [9:0] vin = 10'd0;
  logic       cmp;
  logic [9:0] dac, res;
  logic       smp, eoc;

  exp_t       q[$];
  int         cyc = 0;
  int         t0 = 0;
  int         n_chk = 0;
  int         n_bad = 0;
  logic [9:0] last_res = 10'd0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign cmp = (vin >= dac);

  sar_adc_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .div_sel_i(div), .presc_i(presc),
    .start_i(start), .cmp_i(cmp), .dac_code_o(dac), .sample_o(smp),
    .result_o(res), .eoc_o(eoc)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic int period(input logic [1:0] d, input logic [3:0] n);
    int m;
    m = (d == 2'b00) ? 4 : ((d == 2'b01) ? 64 : 1024);
    return m * (int'(n) + 1);
  endfunction

  task automatic conv(input logic [9:0] v, input logic [1:0] d, input logic [3:0] n,
                      input bit disturb);
    int p;
    exp_t e;
    p = period(d, n);
    e.res = v; e.lat = 16 * p; e.samp = 5 * p;
    q.push_back(e);
    @(negedge clk);
    vin = v; div = d; presc = n; start = 1'b1;
    @(posedge clk); #1;
    t0 = cyc;
    start = 1'b0;
    chk(eoc == 1'b0, "R7 eoc low after accept", int'(eoc), 0);
    chk(dac == 10'd0, "R4 trial cleared on accept", int'(dac), 0);
    chk(res == last_res, "R5 result held during conversion", int'(res), int'(last_res));
    repeat (5 * p) @(posedge clk);
    #1;
    chk(dac == 10'h200, "R4 MSB trial after sampling", int'(dac), 512);
    if (disturb) begin
      @(negedge clk);
      start = 1'b1; div = 2'b10; presc = 4'd15;
      @(negedge clk);
      start = 1'b0;
      repeat (3) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (eoc !== 1'b1) begin
      @(posedge clk); #1;
    end
    last_res = v;
    repeat (7) @(posedge clk);
    #1;
    chk(eoc == 1'b1, "R7 eoc held until next start", int'(eoc), 1);
    chk(res == v, "R5 result stable after completion", int'(res), int'(v));
  endtask

  // monitor: pops expected items at every rising edge of end-of-conversion
  initial begin
    logic prev;
    int   scnt;
    exp_t e;
    prev = 1'b0;
    scnt = 0;
    forever begin
      @(posedge clk); #1;
      if (rst_n) begin
        if (smp) scnt++;
        if (eoc && !prev) begin
          if (q.size() == 0) begin
            chk(1'b0, "R2 unexpected eoc", 1, 0);
          end else begin
            e = q.pop_front();
            chk(res == e.res, "R4 result code", int'(res), int'(e.res));
            chk(cyc - t0 == e.lat, "R2 R1 R6 R8 latency", cyc - t0, e.lat);
            chk(scnt == e.samp, "R3 sample strobe width", scnt, e.samp);
          end
          scnt = 0;
        end
        prev = eoc;
      end else begin
        prev = 1'b0;
        scnt = 0;
      end
    end
  end

  initial begin
    #(200000 * 5);
    chk(1'b0, "R2 watchdog expired", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(eoc == 1'b0 && smp == 1'b0, "R9 reset eoc and strobe", int'({eoc, smp}), 0);
    chk(res == 10'd0 && dac == 10'd0, "R9 reset result and trial", int'(res) + int'(dac), 0);
    @(negedge clk);
    rst_n = 1'b1;
    conv(10'h2A5, 2'b00, 4'd0, 1'b0);   // R1 P=4
    conv(10'h000, 2'b00, 4'd3, 1'b0);   // R1 P=16
    conv(10'h3FF, 2'b00, 4'd15, 1'b0);  // R1 P=64
    conv(10'h155, 2'b01, 4'd1, 1'b0);   // R1 P=128
    conv(10'h200, 2'b10, 4'd0, 1'b0);   // R1 P=1024
    conv(10'h1FF, 2'b11, 4'd0, 1'b0);   // R1 unused code as 1024
    conv(10'h0AA, 2'b00, 4'd2, 1'b1);   // R6 R8 disturbed run, P=12
    conv(10'h001, 2'b00, 4'd0, 1'b0);   // R8 new settings apply
    @(negedge clk);
    vin = 10'h3C3; div = 2'b00; presc = 4'd1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (60) @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk); #1;
    chk(eoc == 1'b0 && smp == 1'b0, "R9 mid-run reset eoc and strobe", int'({eoc, smp}), 0);
    chk(res == 10'd0, "R9 mid-run reset result", int'(res), 0);
    chk(dac == 10'd0, "R9 mid-run reset trial", int'(dac), 0);
    chk(q.size() == 0, "R2 all conversions completed", q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule